// File: doc/BRIEF.md
# Link Transmit Frame Formatter

This block builds the 32-bit word handed to a serial optical link transmitter on every clock. It picks the word from one of several sources, in fixed priority order. A test source sends either a constant word or the state of a 24-bit pseudo-random generator. An idle source is active after reset and sends a word that alternates between two bit patterns, which lets the far end lock on. A payload source carries a 19-bit data field, can add a bunch-crossing marker and count, and can add a check byte.

Configuration arrives through a small write-only register port made of an address, a data byte and a write strobe. A one-cycle command moves the link from idle into payload mode. An orbit marker input restarts the bunch-crossing counter. The word output is registered, so it follows the chosen source with one cycle of latency.

Top module: `lnk_tx_framer`

## Requirements
- R1: While reset is asserted, word_o is 0. After reset is released, the link is idle. Its first word is 0x00555555, and each following cycle toggles between 0x00AAAAAA and 0x00555555.
- R2: The idle source stays selected, whatever data_i and orbit_i do, until go_i is sampled high. The word from the edge that samples go_i is still idle. Payload words begin on the edge after it.
- R3: Bit 7 of the register at address 0x04 enables test mode. Test mode has the highest priority, above idle and above payload. With bit 2 of register 0x4C clear, test mode sends 0x12345678.
- R4: With test mode on and bit 2 of register 0x4C set, the word is {8'h00, s}. Here s is a 24-bit LFSR state that starts at SEED after reset. On each cycle in which this pattern is sent, s advances: the feedback bit is s[23]^s[22]^s[21]^s[16] (x^24+x^23+x^22+x^17+1), and the next state is {s[22:0], fb}.
- R5: With test mode off, bit 2 of register 0x4C has no effect on the word. The LFSR state also does not advance during that time.
- R6: In payload mode with no options set, word bits [18:0] equal data_i and every other bit is 0.
- R7: Bit 1 of register 0x4C enables the bunch fields. Bit 24 is set when the bunch count is 0. Bits [31:25] hold bits [6:0] of the count.
- R8: The bunch counter goes to 0 on the edge that samples orbit_i high. Otherwise it increments by 1 each cycle and goes from BX_MAX back to 0.
- R9: Bit 0 of register 0x4C enables the check byte. Bits [31:24] then hold the XOR of bytes [7:0], [15:8] and [23:16] of the word, and this replaces any bunch-field bits.
- R10: A write changes the output from the second edge after it is sampled onward. A write to any address other than 0x04 or 0x4C leaves the output unchanged.
- R11: In payload mode, word_o at each edge reflects data_i and the counter value present before that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| data_i | input | DATA_W | Payload data bits |
| orbit_i | input | 1 | Orbit marker; restarts the bunch counter |
| go_i | input | 1 | Command to leave idle and enter payload mode |
| word_o | output | 32 | Registered link word |

## Verification
The bench builds the block with BX_MAX set to 40 and leaves every other parameter at its default. With that value the counter wraps many times in a few hundred cycles, so wrap-around, orbit restarts in mid-count and the bunch-zero flag are all exercised repeatedly next to random payload data. The default seed and the 24-bit generator are kept, so every pseudo-random word is compared against a sequence computed arithmetically in the bench. That sequence includes the resumption after a period in which the random select was set without test mode.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned BZ_BIT = 24;
   localparam int unsigned PRBS_W = 24;

   localparam logic [WORD_W-1:0] FIXED_WORD = 32'h1234_5678;
   localparam logic [WORD_W-1:0] IDLE_EVEN  = 32'h0055_5555;
   localparam logic [WORD_W-1:0] IDLE_ODD   = 32'h00AA_AAAA;

   typedef struct packed {
      logic test_en;
      logic rand_sel;
      logic mark_en;
      logic chk_en;
   } lnk_cfg_t;

   function automatic logic [7:0] fold_bytes(input logic [23:0] low);
      return low[7:0] ^ low[15:8] ^ low[23:16];
   endfunction
endpackage

// File: rtl/lnk_cfg_regs.sv
module lnk_cfg_regs
   import lnk_tx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned MODE_ADDR = 'h04,
   parameter int unsigned CTRL_ADDR = 'h4C
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   output lnk_cfg_t          cfg_o
);
   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   if (MODE_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register offsets do not fit ADDR_W");
   end

   logic hit_mode, hit_ctrl;
   assign hit_mode = wr_en_i && (wr_addr_i == MODE_A);
   assign hit_ctrl = wr_en_i && (wr_addr_i == CTRL_A);

   wire unused_wdata = ^wr_data_i[6:3];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cfg_o <= '0;
      end else begin
         if (hit_mode) cfg_o.test_en <= wr_data_i[7];
         if (hit_ctrl) begin
            cfg_o.chk_en   <= wr_data_i[0];
            cfg_o.mark_en  <= wr_data_i[1];
            cfg_o.rand_sel <= wr_data_i[2];
         end
      end
   end

   // R10
   unmapped_ign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_addr_i != MODE_A && wr_addr_i != CTRL_A) |=> $stable(cfg_o));
endmodule

// File: rtl/lnk_bx_counter.sv
module lnk_bx_counter #(
   parameter int unsigned BX_W    = 12,
   parameter int unsigned BX_MAX  = 3563,
   parameter int unsigned FIELD_W = 7
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               orbit_i,
   output logic [FIELD_W-1:0] field_o,
   output logic               zero_o
);
   localparam logic [BX_W-1:0] LAST = BX_W'(BX_MAX);

   if (BX_MAX >= (1 << BX_W) || BX_MAX == 0) begin : g_bad_max
      $error("BX_MAX must be nonzero and fit BX_W");
   end
   if (FIELD_W > BX_W) begin : g_bad_field
      $error("FIELD_W exceeds BX_W");
   end

   logic [BX_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || orbit_i)   cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign field_o = cnt_q[FIELD_W-1:0];
   assign zero_o  = (cnt_q == '0);

   // R8
   bx_orbit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      orbit_i |=> zero_o);
   // R8
   bx_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);
   // R8
   bx_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!orbit_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lnk_prbs24.sv
module lnk_prbs24
   import lnk_tx_pkg::*;
#(
   parameter logic [PRBS_W-1:0] SEED = 24'h5A_C3E1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              adv_i,
   output logic [PRBS_W-1:0] state_o
);
   if (SEED == '0) begin : g_bad_seed
      $error("SEED must be nonzero");
   end

   logic fb;
   assign fb = state_o[23] ^ state_o[22] ^ state_o[21] ^ state_o[16];

   always_ff @(posedge clk_i) begin
      if (rst_i)      state_o <= SEED;
      else if (adv_i) state_o <= {state_o[22:0], fb};
   end

   // R4
   prbs_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o != '0);
   // R5
   prbs_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(state_o));
endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
   import lnk_tx_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 19,
   parameter int unsigned       BX_W      = 12,
   parameter int unsigned       BX_MAX    = 3563,
   parameter int unsigned       BXF_LSB   = 25,
   parameter bit                HAS_CHECK = 1'b1,
   parameter logic [PRBS_W-1:0] SEED      = 24'h5A_C3E1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              orbit_i,
   input  logic              go_i,
   output logic [31:0]       word_o
);
   localparam int unsigned BXF_W = WORD_W - BXF_LSB;

   if (DATA_W == 0 || DATA_W > BZ_BIT) begin : g_bad_data
      $error("DATA_W must lie in 1..24");
   end
   if (BXF_LSB != BZ_BIT + 1) begin : g_bad_bxf
      $error("bunch field must sit just above the zero flag");
   end

   lnk_cfg_t          cfg;
   logic [BXF_W-1:0]  bx_field;
   logic              bx_zero;
   logic [PRBS_W-1:0] prbs;
   logic              prbs_adv;
   logic              idle_q, phase_q;
   logic [31:0]       marked, pay_word, nxt_word;

   lnk_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .cfg_o     (cfg)
   );

   lnk_bx_counter #(.BX_W(BX_W), .BX_MAX(BX_MAX), .FIELD_W(BXF_W)) u_bx (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .orbit_i (orbit_i),
      .field_o (bx_field),
      .zero_o  (bx_zero)
   );

   assign prbs_adv = cfg.test_en && cfg.rand_sel;

   lnk_prbs24 #(.SEED(SEED)) u_prbs (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .adv_i   (prbs_adv),
      .state_o (prbs)
   );

   always_comb begin
      marked = '0;
      marked[DATA_W-1:0] = data_i;
      if (cfg.mark_en) begin
         marked[BZ_BIT]            = bx_zero;
         marked[WORD_W-1:BXF_LSB]  = bx_field;
      end
   end

   if (HAS_CHECK) begin : g_chk
      assign pay_word = cfg.chk_en ? {fold_bytes(marked[23:0]), marked[23:0]} : marked;
   end else begin : g_nochk
      assign pay_word = marked;
   end

   always_comb begin
      if (cfg.test_en)  nxt_word = cfg.rand_sel ? {8'h00, prbs} : FIXED_WORD;
      else if (idle_q)  nxt_word = phase_q ? IDLE_ODD : IDLE_EVEN;
      else              nxt_word = pay_word;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         idle_q  <= 1'b1;
         phase_q <= 1'b0;
         word_o  <= '0;
      end else begin
         phase_q <= ~phase_q;
         if (go_i) idle_q <= 1'b0;
         word_o  <= nxt_word;
      end
   end

   // R2
   idle_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (idle_q && !go_i) |=> idle_q);
   // R1
   idle_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (idle_q && !cfg.test_en) |=> (word_o == IDLE_EVEN || word_o == IDLE_ODD));
   // R3
   test_fixed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg.test_en && !cfg.rand_sel) |=> word_o == FIXED_WORD);
   // R6
   payload_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!idle_q && !cfg.test_en) |=> word_o[BZ_BIT-1:DATA_W] == '0);
endmodule

// File: tb/lnk_tx_framer_bench.sv
module lnk_tx_framer_bench;
   localparam int unsigned BXM  = 40;
   localparam logic [23:0] SEED = 24'h5A_C3E1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [18:0] data = '0;
   logic        orbit = 1'b0;
   logic        go = 1'b0;
   logic [31:0] word;

   int    n_run = 0;
   int    n_fail = 0;
   string cur = "R1";

   logic        m_idle = 1'b1, m_phase = 1'b0;
   logic        m_test = 1'b0, m_rand = 1'b0, m_mark = 1'b0, m_chk = 1'b0;
   int          m_cnt = 0;
   logic [23:0] m_lfsr = SEED;

   always #2 clk = ~clk;

   lnk_tx_framer #(.BX_MAX(BXM), .SEED(SEED)) u_lnk_tx_framer (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .data_i(data), .orbit_i(orbit), .go_i(go),
      .word_o(word)
   );

   function automatic logic [31:0] pay(input logic [18:0] d, input int c,
                                       input logic mk, input logic ck);
      logic [31:0] w;
      logic [6:0]  c7;
      w = 32'(d);
      c7 = 7'(c);
      if (mk) w = w | (32'(c == 0) << 24) | (32'(c7) << 25);
      if (ck) w = {w[7:0] ^ w[15:8] ^ w[23:16], w[23:0]};
      return w;
   endfunction

   task automatic cyc();
      logic [31:0] exp_w;
      if (rst) begin
         exp_w = '0;
      end else if (m_test) begin
         exp_w = m_rand ? {8'h00, m_lfsr} : 32'h1234_5678;
      end else if (m_idle) begin
         exp_w = m_phase ? 32'h00AA_AAAA : 32'h0055_5555;
      end else begin
         exp_w = pay(data, m_cnt, m_mark, m_chk);
      end
      // advance the model across the coming edge
      if (rst) begin
         m_idle = 1'b1; m_phase = 1'b0; m_cnt = 0; m_lfsr = SEED;
         m_test = 1'b0; m_rand = 1'b0; m_mark = 1'b0; m_chk = 1'b0;
      end else begin
         if (m_test && m_rand)
            m_lfsr = {m_lfsr[22:0], m_lfsr[23] ^ m_lfsr[22] ^ m_lfsr[21] ^ m_lfsr[16]};
         m_phase = ~m_phase;
         if (go) m_idle = 1'b0;
         if (orbit || m_cnt == BXM) m_cnt = 0;
         else m_cnt = m_cnt + 1;
         if (wr_en && wr_addr == 8'h04) m_test = wr_data[7];
         if (wr_en && wr_addr == 8'h4C) begin
            m_chk = wr_data[0]; m_mark = wr_data[1]; m_rand = wr_data[2];
         end
      end
      @(posedge clk);
      #1;
      n_run++;
      if (word !== exp_w) begin
         n_fail++;
         $display("FAIL %s: word_o=%h expected %h", cur, word, exp_w);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic run(input int n, input bit rnd_data);
      for (int i = 0; i < n; i++) begin
         if (rnd_data) data = 19'($urandom);
         cyc();
      end
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL R11: watchdog expired, actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset value, then alternating idle words
      cur = "R1";
      run(3, 1'b1);
      rst = 1'b0;
      run(8, 1'b1);
      // R2: data and orbit do not leave idle
      cur = "R2";
      orbit = 1'b1; run(2, 1'b1); orbit = 1'b0;
      run(4, 1'b1);
      // R3: test mode outranks idle
      cur = "R3";
      wr(8'h04, 8'h80);
      run(5, 1'b1);
      // R10: unmapped writes while test mode is on
      cur = "R10";
      wr(8'h08, 8'h00);
      wr(8'h05, 8'h00);
      wr(8'h4D, 8'hFF);
      run(3, 1'b1);
      wr(8'h04, 8'h00);
      cur = "R2";
      run(3, 1'b1);
      go = 1'b1; cyc(); go = 1'b0;
      // R6 and R11: plain payload, fresh data each cycle
      cur = "R6";
      data = 19'h7FFFF; cyc();
      data = 19'h00000; cyc();
      data = 19'h55555; cyc();
      cur = "R11";
      run(30, 1'b1);
      // R5: random select without test mode
      cur = "R5";
      wr(8'h4C, 8'h04);
      run(12, 1'b1);
      // R4: pseudo-random words resume from the unadvanced seed
      cur = "R4";
      wr(8'h04, 8'h80);
      run(70, 1'b1);
      wr(8'h04, 8'h00);
      // R7 and R8: bunch fields with wrap and orbit restarts
      cur = "R7";
      wr(8'h4C, 8'h02);
      run(50, 1'b1);
      cur = "R8";
      run(60, 1'b1);
      orbit = 1'b1; cyc(); orbit = 1'b0;
      run(15, 1'b1);
      orbit = 1'b1; cyc(); cyc(); orbit = 1'b0;
      run(50, 1'b1);
      // R9: check byte overrides the bunch fields
      cur = "R9";
      wr(8'h4C, 8'h03);
      run(90, 1'b1);
      wr(8'h4C, 8'h01);
      run(30, 1'b1);
      // R10: unmapped writes in payload mode
      cur = "R10";
      wr(8'h00, 8'hFF);
      wr(8'hCC, 8'h80);
      run(5, 1'b1);
      // R3: test mode outranks payload with options on
      cur = "R3";
      wr(8'h4C, 8'h03);
      wr(8'h04, 8'h80);
      run(6, 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule